// File: doc/BRIEF.md
# Probabilistic Hybrid Batch Arbiter

This block picks which source's head-of-line batch is forwarded next toward the per-bank command queues of a memory controller. Each source reports whether its oldest batch is ready, and how many memory requests it has outstanding. At every decision the arbiter uses one of two policies. Shortest-job-first picks the ready source with the fewest outstanding requests. Round-robin rotates through the ready sources so that heavy sources still make progress.

A free-running 16-bit linear feedback shift register is compared against a threshold that software programs, and the result picks the policy for that decision. A small threshold favours round-robin, which suits a bandwidth-hungry graphics source. A threshold near the top of its range makes shortest-job-first dominant. After a grant is issued, it stays fixed until the granted source's final request of the batch is accepted downstream.

The controller has two states. IDLE waits for any ready source; the DECIDE transition (IDLE to HOLD) happens on the first edge where some source is ready. HOLD keeps the grant; the RELEASE transition (HOLD to IDLE) happens on the edge where a last-of-batch request is accepted. While in IDLE with no ready source, the controller stays in IDLE (WAIT).

Top module: `hybrid_batch_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `grant_valid` and `grant_sjf` are low, and the round-robin pointer is at source 0.
- R2: While `grant_valid` is high, `grant` has exactly one bit set; while it is low, `grant` is zero. In IDLE with no ready source, no grant is issued.
- R3: While in HOLD, `grant` and `grant_sjf` do not change, whatever happens on `src_ready` and `src_count`, and whatever happens on `drain_fire` or `drain_last` when they are not both high.
- R4: On the edge where `drain_fire` and `drain_last` are both high in HOLD, the grant is released, so `grant_valid` is low for at least the following cycle. The next decision is taken on the next edge where some source is ready.
- R5: The LFSR is 16 bits, free-running and never zero. A decision uses shortest-job-first when the LFSR value is less than or equal to `p_thresh`, and round-robin otherwise. With `p_thresh`=0 every decision is round-robin; with `p_thresh`=16'hFFFF every decision is shortest-job-first.
- R6: In shortest-job-first mode, the grant goes to the ready source with the smallest `src_count` field. Source i's count is at bits [i*CW +: CW]. Ties go to the lowest index.
- R7: In round-robin mode, the grant goes to the first ready source at or after the pointer, searching upward and wrapping. After a round-robin grant to source k, the pointer becomes (k+1) mod N.
- R8: A shortest-job-first grant leaves the round-robin pointer unchanged.
- R9: With an intermediate `p_thresh`, the fraction of shortest-job-first decisions over several thousand decisions lies within 0.05 of `p_thresh`/65536.
- R10: `grant_sjf` is high exactly when the current grant was made by shortest-job-first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_thresh | input | 16 | Threshold that sets the shortest-job-first probability |
| src_ready | input | N | Per-source: oldest batch ready |
| src_count | input | N*CW | Per-source outstanding-request counts, packed |
| drain_fire | input | 1 | A request of the granted batch is accepted |
| drain_last | input | 1 | The accepted request is the last of its batch |
| grant | output | N | One-hot grant |
| grant_valid | output | 1 | A grant is active |
| grant_sjf | output | 1 | The active grant came from shortest-job-first |

## Verification
Some properties are checked by assertions on every cycle:
- the grant is one-hot,
- the grant stays stable across HOLD,
- no grant is issued from IDLE with nothing ready,
- the policy is forced at both extreme thresholds.

Other behaviour only the bench scenarios can show: that the winner is the correct source, how the round-robin pointer evolves across mixed-policy sequences, and the statistical policy ratio at intermediate thresholds. For these, the bench sweeps every ready pattern against a grid of count values for four sources and compares each grant with a model of the pointer.

// File: rtl/hba_pkg.sv
package hba_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_HOLD = 1'b1
    } arb_state_t;

    typedef enum logic [0:0] {
        POL_RR  = 1'b0,
        POL_SJF = 1'b1
    } policy_t;

    localparam int LFSR_W = 16;
endpackage

// File: rtl/hba_lfsr.sv
module hba_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED[W-1:0];
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS[W-1:0];
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q;

    // R5: the register must never lock up at zero
    p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/hba_sjf_pick.sv
module hba_sjf_pick #(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic [N-1:0]    ready,
    input  logic [N*CW-1:0] counts,
    output logic [N-1:0]    pick
);
    always_comb begin
        logic [CW-1:0] best;
        logic          found;
        pick  = '0;
        best  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ready[i] && (!found || counts[i*CW +: CW] < best)) begin
                best  = counts[i*CW +: CW];
                found = 1'b1;
                pick  = '0;
                pick[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hba_rr_pick.sv
module hba_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  ready,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick,
    output logic [PW-1:0] next_ptr
);
    always_comb begin
        logic found;
        int   idx;
        pick     = '0;
        next_ptr = ptr;
        found    = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && ready[idx]) begin
                found     = 1'b1;
                pick[idx] = 1'b1;
                next_ptr  = (idx == N - 1) ? '0 : PW'(idx + 1);
            end
        end
    end
endmodule

// File: rtl/hybrid_batch_arbiter.sv
module hybrid_batch_arbiter
    import hba_pkg::*;
#(
    parameter int N  = 4,
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     p_thresh,
    input  logic [N-1:0]    src_ready,
    input  logic [N*CW-1:0] src_count,
    input  logic            drain_fire,
    input  logic            drain_last,
    output logic [N-1:0]    grant,
    output logic            grant_valid,
    output logic            grant_sjf
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    arb_state_t   state_q, state_d;
    logic [PW-1:0] rr_ptr_q;
    logic [N-1:0]  sjf_oh, rr_oh;
    logic [PW-1:0] rr_next;
    logic [LFSR_W-1:0] rnd;
    logic          any_ready, release_now, decide_now;
    policy_t       pol_now;

    hba_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    hba_sjf_pick #(.N(N), .CW(CW)) u_sjf (
        .ready  (src_ready),
        .counts (src_count),
        .pick   (sjf_oh)
    );

    hba_rr_pick #(.N(N), .PW(PW)) u_rr (
        .ready    (src_ready),
        .ptr      (rr_ptr_q),
        .pick     (rr_oh),
        .next_ptr (rr_next)
    );

    assign any_ready   = |src_ready;
    assign release_now = drain_fire && drain_last;
    assign pol_now     = (rnd <= p_thresh) ? POL_SJF : POL_RR;
    assign decide_now  = (state_q == S_IDLE) && any_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_ready)   state_d = S_HOLD;
            S_HOLD: if (release_now) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_valid <= 1'b0;
            grant_sjf   <= 1'b0;
            rr_ptr_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (any_ready) begin
                        grant_valid <= 1'b1;
                        grant_sjf   <= (pol_now == POL_SJF);
                        if (pol_now == POL_SJF) begin
                            grant <= sjf_oh;
                        end else begin
                            grant    <= rr_oh;
                            rr_ptr_q <= rr_next;
                        end
                    end
                end
                S_HOLD: begin
                    if (release_now) begin
                        grant       <= '0;
                        grant_valid <= 1'b0;
                        grant_sjf   <= 1'b0;
                    end
                end
                default: begin
                    grant       <= '0;
                    grant_valid <= 1'b0;
                end
            endcase
        end
    end

    // R2: one-hot grant whenever valid, zero otherwise
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid ? $onehot(grant) : (grant == '0));

    // R2: nothing ready in IDLE -> no grant on the next cycle
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !any_ready) |=> !grant_valid);

    // R3: grant held through HOLD until release
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && !release_now) |=> ($stable(grant) && $stable(grant_sjf) && grant_valid));

    // R4: release drops the grant
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && release_now) |=> !grant_valid);

    // R5: zero threshold forces round-robin
    p_zero_rr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && p_thresh == 16'h0000) |=> !grant_sjf);

    // R5: full threshold forces shortest-job-first
    p_full_sjf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && p_thresh == 16'hFFFF) |=> grant_sjf);

    // R8: a shortest-job-first grant leaves the pointer untouched
    p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_now && pol_now == POL_SJF) |=> $stable(rr_ptr_q));
endmodule

// File: tb/hybrid_batch_arbiter_test.sv
module hybrid_batch_arbiter_test;
    localparam int N  = 4;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [15:0]     p_thresh = '0;
    logic [N-1:0]    src_ready = '0;
    logic [N*CW-1:0] src_count = '0;
    logic            drain_fire = 1'b0;
    logic            drain_last = 1'b0;
    logic [N-1:0]    grant;
    logic            grant_valid;
    logic            grant_sjf;

    int checks = 0;
    int fails  = 0;
    int mptr   = 0;
    int sjf_seen = 0;
    int dec_seen = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    hybrid_batch_arbiter #(.N(N), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .p_thresh(p_thresh),
        .src_ready(src_ready), .src_count(src_count),
        .drain_fire(drain_fire), .drain_last(drain_last),
        .grant(grant), .grant_valid(grant_valid), .grant_sjf(grant_sjf)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int oh_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int sjf_exp(input logic [N-1:0] r, input logic [N*CW-1:0] c);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && (best < 0 || c[i*CW +: CW] < c[best*CW +: CW])) best = i;
        return best;
    endfunction

    function automatic int rr_exp(input logic [N-1:0] r, input int p);
        for (int k = 0; k < N; k++) if (r[(p + k) % N]) return (p + k) % N;
        return -1;
    endfunction

    // Called just after a falling edge. force_pol: 0 none, 1 expect RR, 2 expect SJF.
    task automatic decide(input logic [N-1:0] r, input logic [N*CW-1:0] c, input int force_pol, input string req);
        int g, e;
        src_ready = r;
        src_count = c;
        @(negedge clk);
        check(grant_valid === 1'b1, "R2 valid after decision", int'(grant_valid), 1);
        check($onehot(grant), "R2 one-hot", int'(grant), 0);
        g = oh_idx(grant);
        if (force_pol == 1) check(grant_sjf === 1'b0, "R5 forced round-robin", int'(grant_sjf), 0);
        if (force_pol == 2) check(grant_sjf === 1'b1, "R5 forced shortest-job-first", int'(grant_sjf), 1);
        if (grant_sjf) begin
            e = sjf_exp(r, c);
            check(g == e, {req, " R6 SJF winner R10"}, g, e);
            sjf_seen++;
        end else begin
            e = rr_exp(r, mptr);
            check(g == e, {req, " R7 RR winner R10"}, g, e);
            if (g >= 0) mptr = (g + 1) % N;
        end
        dec_seen++;
        drain_fire = 1'b1;
        drain_last = 1'b1;
        @(negedge clk);
        check(grant_valid === 1'b0 && grant == '0, "R4 release", int'(grant_valid), 0);
        drain_fire = 1'b0;
        drain_last = 1'b0;
        src_ready  = '0;
    endtask

    initial begin
        int first, ratio_ok;
        real ratio, target;
        logic [N*CW-1:0] c;
        logic [3:0] vals [3];
        vals[0] = 4'd0; vals[1] = 4'd5; vals[2] = 4'd15;

        repeat (3) @(negedge clk);
        check(grant === '0 && grant_valid === 1'b0 && grant_sjf === 1'b0, "R1 reset state", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: nothing ready -> no grant
        repeat (3) begin
            @(negedge clk);
            check(grant_valid === 1'b0, "R2 idle with no ready", int'(grant_valid), 0);
        end

        // R7, R1: round-robin from pointer 0 with all ready: 0,1,2,3,0
        p_thresh = 16'h0000;
        for (int k = 0; k < 5; k++) begin
            decide(4'hF, 16'h1234, 1, "R7 rotation");
            check(mptr == (k + 1) % N, "R7 pointer rotation", mptr, (k + 1) % N);
        end

        // R5, R6: sweep with full threshold
        p_thresh = 16'hFFFF;
        for (int r = 1; r < 16; r++)
            for (int a = 0; a < 81; a++) begin
                int t = a;
                for (int i = 0; i < N; i++) begin
                    c[i*CW +: CW] = (i < 4) ? vals[t % 3] : '0;
                    t = t / 3;
                end
                decide(4'(r), c, 2, "R6 sweep");
            end

        // R7: round-robin across every ready subset, twice around
        p_thresh = 16'h0000;
        for (int rep = 0; rep < 2; rep++)
            for (int r = 1; r < 16; r++) decide(4'(r), 16'hFFFF, 1, "R7 subsets");

        // R8: SJF grant in between leaves the pointer
        first = mptr;
        p_thresh = 16'hFFFF;
        decide(4'hF, {4'd9, 4'd9, 4'd9, 4'd9} & ~(16'hF << (((first + 2) % N) * CW)), 2, "R8 SJF middle");
        p_thresh = 16'h0000;
        decide(4'hF, 16'h0, 1, "R8 RR after SJF");
        check(mptr == (first + 1) % N, "R8 pointer unaffected by SJF", mptr, (first + 1) % N);

        // R3: hold while inputs churn
        p_thresh = 16'h0000;
        src_ready = 4'b0110;
        src_count = 16'h0;
        @(negedge clk);
        first = oh_idx(grant);
        check(first == rr_exp(4'b0110, mptr), "R3 initial hold grant", first, rr_exp(4'b0110, mptr));
        mptr = (first + 1) % N;
        for (int k = 0; k < 8; k++) begin
            src_ready  = 4'(k * 5 + 3);
            src_count  = 16'(k * 16'h1357);
            p_thresh   = 16'(k * 16'h2222);
            drain_fire = k[0];
            drain_last = ~k[0];
            @(negedge clk);
            check(grant_valid === 1'b1 && oh_idx(grant) == first && grant_sjf === 1'b0,
                  "R3 grant held", oh_idx(grant), first);
        end
        drain_fire = 1'b1; drain_last = 1'b1; src_ready = '0;
        @(negedge clk);
        check(grant_valid === 1'b0, "R4 release after hold", int'(grant_valid), 0);
        drain_fire = 1'b0; drain_last = 1'b0;

        // R9: intermediate thresholds
        for (int pi = 0; pi < 2; pi++) begin
            p_thresh = (pi == 0) ? 16'h8000 : 16'hE666;
            sjf_seen = 0;
            dec_seen = 0;
            for (int k = 0; k < 3000; k++)
                decide(4'hF, 16'(k * 16'h3A5B), 0, "R9 mixed");
            ratio  = real'(sjf_seen) / real'(dec_seen);
            target = real'(p_thresh) / 65536.0;
            ratio_ok = (ratio > target - 0.05 && ratio < target + 0.05) ? 1 : 0;
            check(ratio_ok == 1, "R9 policy ratio (permille)", int'(ratio * 1000.0), int'(target * 1000.0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule